// File: doc/BRIEF.md
# Dual-Slope Center-Aligned PWM Timer

This block produces a symmetric PWM waveform on one output channel. A counter of configurable width climbs from zero to a programmable ceiling, then falls back to zero, and keeps repeating that triangle. The counter moves one step only on cycles where a prescaler pulses its enable. The prescaler divides the main clock by 1, 8, 64, 256 or 1024, and it can also stop the counter altogether. A full PWM period therefore lasts 2 × N × TOP main clock cycles, where N is the prescale factor.

A compare value is written into a holding register. It becomes the active threshold only when the counter leaves zero, so both halves of every period use the same threshold. When the counter passes the threshold on the way up, the waveform falls. When it passes the threshold on the way down, the waveform rises. A two-bit mode field chooses one of three behaviours for the output pin: driven low, the waveform as is, or the waveform inverted. An enable input gates the pin, in the way a pin direction control would. A sticky match flag records each pass of the threshold, and a clear pulse resets it.

Top module: `pwm_dual_slope`

## Requirements
- R1: After reset, cnt_o, cmp_o, flag_o and pin_o are all 0, and the counter is heading upward.
- R2: presc_sel_i chooses the tick period. Code 1 gives a tick every cycle, 2 every 8 cycles, 3 every 64, 4 every 256 and 5 every 1024. Codes 0, 6 and 7 stop the counter. When the code changes from a stopped code or from 1, the first tick arrives N cycles later.
- R3: On each tick the counter steps by one. It goes 0,1,…,TOP,TOP-1,…,1,0,1,… and holds each extreme for exactly one tick, so a period lasts 2×TOP ticks. A TOP of 0 holds the counter at 0.
- R4: With mode_i = 2 (non-inverted) and 0 < compare < TOP, the tick that leaves 0 drives the waveform high. A tick taken at count == compare while counting up drives it low, and the same tick while counting down drives it high.
- R5: With mode_i = 3 (inverted), pin_o is the complement of the non-inverted waveform.
- R6: In non-inverted mode, an active compare of 0 keeps the pin low through the whole period. An active compare of TOP or above keeps it high. Inverted mode gives the opposite levels.
- R7: pin_o is 0 whenever oe_i is 0 or mode_i is 0 or 1. pin_o is registered, so it follows mode_i and oe_i one clock edge later.
- R8: A pulse on cmp_wr_i loads only the holding register. The active compare (cmp_o) takes the held value on the tick at which cnt_o is 0, and at no other time.
- R9: flag_o is set by any tick taken while cnt_o equals the active compare (for the tick that leaves 0, the newly loaded value). It stays set until it is cleared.
- R10: A flag_clr_i pulse clears flag_o on the next edge. If a setting tick happens on that same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_sel_i | input | 3 | Prescale code (0 stop, 1 /1, 2 /8, 3 /64, 4 /256, 5 /1024) |
| top_i | input | WIDTH | Upper turning point of the count |
| cmp_wr_i | input | 1 | Write strobe for the compare holding register |
| cmp_wdata_i | input | WIDTH | Compare value to hold |
| mode_i | input | 2 | Output mode: 0/1 off, 2 non-inverted, 3 inverted |
| oe_i | input | 1 | Pin drive enable |
| flag_clr_i | input | 1 | Clears the match flag |
| cnt_o | output | WIDTH | Current count |
| cmp_o | output | WIDTH | Active compare value |
| flag_o | output | 1 | Sticky compare-match flag |
| pin_o | output | 1 | Gated PWM output |

## Verification
The bench builds the block with WIDTH = 8 and TOP = 4. With those values a whole triangle lasts only eight ticks, so each path through the design is reached in a few cycles: the tick that leaves zero, the turn at TOP, an up-count match, a down-count match, a compare of 0, a compare equal to TOP, a compare above TOP, and a holding-register write made in the middle of a period. Every prescale code is run for an exact multiple of its divide ratio, including 1024, so each tick lands on a known cycle, and the stop codes are shown to freeze the count.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned DIV_W = 10;

  typedef enum logic [1:0] {
    OUT_OFF   = 2'd0,
    OUT_OFF_B = 2'd1,
    OUT_TRUE  = 2'd2,
    OUT_INV   = 2'd3
  } out_mode_e;

  // terminal value of the divider for each prescale code
  function automatic logic [DIV_W-1:0] presc_limit(input logic [2:0] sel);
    case (sel)
      3'd2:    presc_limit = DIV_W'(7);
      3'd3:    presc_limit = DIV_W'(63);
      3'd4:    presc_limit = DIV_W'(255);
      3'd5:    presc_limit = DIV_W'(1023);
      default: presc_limit = '0;
    endcase
  endfunction

  function automatic logic presc_run(input logic [2:0] sel);
    presc_run = (sel != 3'd0) && (sel <= 3'd5);
  endfunction
endpackage

// File: rtl/pwm_presc.sv
module pwm_presc
  import pwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] div_q;
  logic             run;

  assign run    = presc_run(sel_i);
  assign tick_o = run && (div_q >= presc_limit(sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          div_q <= '0;
    else if (!run)        div_q <= '0;
    else if (tick_o)      div_q <= '0;
    else                  div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_tri_cnt.sv
module pwm_tri_cnt #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [WIDTH-1:0] top_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             up_o
);
  logic [WIDTH-1:0] cnt_q;
  logic             up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick_i) begin
      if (top_i == '0) begin
        cnt_q <= '0;
        up_q  <= 1'b1;
      end else if (up_q) begin
        if (cnt_q >= top_i) begin
          cnt_q <= cnt_q - 1'b1;
          up_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_q <= cnt_q + 1'b1;
          up_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;
endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit
  import pwm_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_i,
  input  logic [WIDTH-1:0] top_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [1:0]       mode_i,
  input  logic             oe_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] cmp_o,
  output logic             flag_o,
  output logic             pin_o
);
  logic [WIDTH-1:0] hold_q, act_q, cmp_eff;
  logic             wave_q, wave_d, flag_q, pin_q, pin_d, at_bot, hit;
  out_mode_e        mode;

  assign mode    = out_mode_e'(mode_i);
  assign at_bot  = tick_i && (cnt_i == '0);
  assign cmp_eff = at_bot ? hold_q : act_q;
  assign hit     = tick_i && (cnt_i == cmp_eff);

  always_comb begin
    wave_d = wave_q;
    if (at_bot)
      wave_d = (cmp_eff != '0);
    else if (hit && (cmp_eff < top_i))
      wave_d = !up_i;  // fall on the way up, rise on the way down
  end

  always_comb begin
    pin_d = 1'b0;
    if (oe_i) begin
      case (mode)
        OUT_TRUE: pin_d = wave_d;
        OUT_INV:  pin_d = !wave_d;
        default:  pin_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      act_q  <= '0;
      wave_q <= 1'b0;
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      if (wr_i)   hold_q <= wdata_i;
      if (at_bot) act_q  <= hold_q;
      wave_q <= wave_d;
      pin_q  <= pin_d;
      if (hit)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cmp_o  = act_q;
  assign flag_o = flag_q;
  assign pin_o  = pin_q;
endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       presc_sel_i,
  input  logic [WIDTH-1:0] top_i,
  input  logic             cmp_wr_i,
  input  logic [WIDTH-1:0] cmp_wdata_i,
  input  logic [1:0]       mode_i,
  input  logic             oe_i,
  input  logic             flag_clr_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic [WIDTH-1:0] cmp_o,
  output logic             flag_o,
  output logic             pin_o
);
  logic tick, up;

  pwm_presc u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (presc_sel_i),
    .tick_o (tick)
  );

  pwm_tri_cnt #(.WIDTH(WIDTH)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .top_i  (top_i),
    .cnt_o  (cnt_o),
    .up_o   (up)
  );

  pwm_cmp_unit #(.WIDTH(WIDTH)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .cnt_i   (cnt_o),
    .up_i    (up),
    .top_i   (top_i),
    .wr_i    (cmp_wr_i),
    .wdata_i (cmp_wdata_i),
    .mode_i  (mode_i),
    .oe_i    (oe_i),
    .clr_i   (flag_clr_i),
    .cmp_o   (cmp_o),
    .flag_o  (flag_o),
    .pin_o   (pin_o)
  );
endmodule

// File: rtl/pwm_dual_slope_chk.sv
module pwm_dual_slope_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       presc_sel_i,
  input logic [WIDTH-1:0] top_i,
  input logic [1:0]       mode_i,
  input logic             oe_i,
  input logic             flag_clr_i,
  input logic [WIDTH-1:0] cnt_o,
  input logic [WIDTH-1:0] cmp_o,
  input logic             flag_o,
  input logic             pin_o
);
  // R2
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (presc_sel_i == 3'd0) |=> $stable(cnt_o));

  // R3
  unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(top_i) && top_i != '0 && cnt_o <= top_i) |=>
      (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1 || cnt_o == $past(cnt_o) - 1'b1));

  // R3
  below_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(top_i) && cnt_o <= top_i) |=> (cnt_o <= top_i));

  // R7
  pin_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_i || !mode_i[1]) |=> !pin_o);

  // R8
  cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != '0) |=> $stable(cmp_o));

  // R9
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> ($past(cnt_o) == $past(cmp_o) || $past(cnt_o) == '0));

  // R10
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && cnt_o != '0 && cnt_o != cmp_o) |=> !flag_o);

  // R6
  zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_o == '0 && cnt_o != '0 && mode_i == 2'd2 && oe_i) |=> !pin_o);
endmodule

bind pwm_dual_slope pwm_dual_slope_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .presc_sel_i (presc_sel_i),
  .top_i       (top_i),
  .mode_i      (mode_i),
  .oe_i        (oe_i),
  .flag_clr_i  (flag_clr_i),
  .cnt_o       (cnt_o),
  .cmp_o       (cmp_o),
  .flag_o      (flag_o),
  .pin_o       (pin_o)
);

// File: tb/pwm_dual_slope_test.sv
module pwm_dual_slope_test;
  localparam int W   = 8;
  localparam int TOP = 4;

  logic         clk, rst_n;
  logic [2:0]   sel;
  logic [W-1:0] top, wdata;
  logic         wr, oe, clr;
  logic [1:0]   mode;
  logic [W-1:0] cnt, cmp;
  logic         flag, pin;

  pwm_dual_slope #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .presc_sel_i(sel), .top_i(top),
    .cmp_wr_i(wr), .cmp_wdata_i(wdata), .mode_i(mode), .oe_i(oe),
    .flag_clr_i(clr), .cnt_o(cnt), .cmp_o(cmp), .flag_o(flag), .pin_o(pin)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    string tag;
    int    kind;  // 0 cnt, 1 pin, 2 flag, 3 cmp
    int    exp;
  } item_t;

  item_t q[$];
  int    n_vec = 0, n_bad = 0;
  bit    done  = 0;

  // reference state
  int k = 0, c_act = 0, c_buf = 0, ph = 0;
  bit high = 0, flg = 0;
  string t_cnt, t_pin, t_flag, t_cmp;

  function automatic int tri_of(int kk);
    int pos = kk % (2 * TOP);
    return (pos <= TOP) ? pos : 2 * TOP - pos;
  endfunction

  function automatic bit level_of(int kk, int c);
    int pos = kk % (2 * TOP);
    int v   = tri_of(kk);
    if (pos >= 1 && pos <= TOP) return v <= c;
    return v < c;
  endfunction

  function automatic int div_of(logic [2:0] s);
    case (s)
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 64;
      3'd4: return 256;
      3'd5: return 1024;
      default: return 0;
    endcase
  endfunction

  task automatic push(string tag, int kind, int exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  // driver: apply one cycle of stimulus, advance the reference, queue expectations
  task automatic step(bit do_clr, bit do_wr, int wd);
    bit tk, set_now, p;
    int n;
    clr = do_clr; wr = do_wr; wdata = W'(wd);
    @(posedge clk);
    #1;
    n  = div_of(sel);
    tk = 0;
    if (n == 0) ph = 0;
    else begin
      ph++;
      if (ph == n) begin tk = 1; ph = 0; end
    end
    set_now = 0;
    if (tk) begin
      if (tri_of(k) == 0) c_act = c_buf;
      set_now = (tri_of(k) == c_act);
      k++;
      high = level_of(k, c_act);
    end
    if (set_now) flg = 1;
    else if (do_clr) flg = 0;
    if (do_wr) c_buf = wd;
    p = (oe && mode[1]) ? (high ^ mode[0]) : 1'b0;
    push(t_cnt, 0, tri_of(k));
    push(t_pin, 1, int'(p));
    push(do_clr ? "R10" : t_flag, 2, int'(flg));
    push(t_cmp, 3, c_act);
    clr = 0; wr = 0;
  endtask

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        0: act = int'(cnt);
        1: act = int'(pin);
        2: act = int'(flag);
        default: act = int'(cmp);
      endcase
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sel = 0; top = W'(TOP); wdata = 0; wr = 0; oe = 0; clr = 0; mode = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    t_cnt = "R1"; t_pin = "R1"; t_flag = "R1"; t_cmp = "R1";
    step(0, 0, 0);

    // R8 write held while stopped, R2 stopped counter
    mode = 2'd2; oe = 1;
    t_cnt = "R2"; t_pin = "R7"; t_flag = "R9"; t_cmp = "R8";
    step(0, 1, 2);
    for (int i = 0; i < 3; i++) step(0, 0, 0);

    // R3 triangle, R4 non-inverted, R9/R10 flag
    sel = 3'd1;
    t_cnt = "R3"; t_pin = "R4";
    for (int i = 0; i < 20; i++) step(i == 10 || i == 14, 0, 0);

    // R5 inverted
    mode = 2'd3; t_pin = "R5";
    for (int i = 0; i < 10; i++) step(i == 4, 0, 0);

    // R7 gating
    t_pin = "R7";
    oe = 0;
    for (int i = 0; i < 4; i++) step(0, 0, 0);
    oe = 1; mode = 2'd0;
    for (int i = 0; i < 4; i++) step(0, 0, 0);
    mode = 2'd1;
    for (int i = 0; i < 4; i++) step(0, 0, 0);

    // R6 extremes, R8 mid-period writes
    mode = 2'd2; t_pin = "R6";
    step(0, 1, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0);
    step(0, 1, TOP);
    for (int i = 0; i < 20; i++) step(i == 3, 0, 0);
    step(0, 1, TOP + 3);
    for (int i = 0; i < 20; i++) step(0, 0, 0);
    mode = 2'd3;
    for (int i = 0; i < 8; i++) step(0, 0, 0);
    mode = 2'd2; t_pin = "R4";
    step(0, 1, 1);
    for (int i = 0; i < 12; i++) step(0, 0, 0);

    // R2 prescale ratios
    t_cnt = "R2";
    sel = 3'd2; for (int i = 0; i < 24; i++)   step(0, 0, 0);
    sel = 3'd3; for (int i = 0; i < 128; i++)  step(0, 0, 0);
    sel = 3'd4; for (int i = 0; i < 512; i++)  step(0, 0, 0);
    sel = 3'd5; for (int i = 0; i < 2048; i++) step(0, 0, 0);
    sel = 3'd6; for (int i = 0; i < 20; i++)   step(0, 0, 0);

    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule